// File: doc/BRIEF.md
# Command Block Framer

This block is the byte-level link layer of a single-wire authentication device. It sits between a token interface, which turns bus pulses into bytes and bytes back into pulses, and a command engine. Every byte that arrives while the link is idle is treated as a flag. One flag opens a command block, one asks for the pending response and one puts the device to sleep. All other flag values are dropped. A command block carries its own length and a CRC-16. The block is checked as it arrives, and a good packet goes to the engine as an opcode, param1, a little-endian 16-bit param2 and a data area that can be read by address.

The framer always holds one current response and sends it as a complete block each time a transmit flag arrives. That response can be one of three things:
- the wake status 0x11, right after reset or wake;
- a parse-error code 0xFF or an execution-error code 0x0F;
- the result packet written by the engine.

While the engine is busy, the framer ignores the bus. A sleep flag discards everything, and the link stays silent until the next wake.

Top module: `cmd_framer`

## Requirements
- R1: After reset, and after every wake, a transmit flag (0x88) returns the 4-byte block 0x04, 0x11, CRC low, CRC high.
- R2: After flag 0x77, a block whose count byte lies in 7..39 and whose CRC matches produces a one-cycle `cmd_valid` pulse. The pulse carries packet byte 0 as `cmd_opcode`, packet byte 1 as `cmd_param1`, and packet bytes 2 and 3 as `cmd_param2` (low byte first). `cmd_data_len` is set to count minus 7. Data byte i is returned on `eng_rd_data` one cycle after `eng_rd_addr` = i.
- R3: The count byte includes itself and both CRC bytes. The CRC-16 uses polynomial 0x8005 and starts at zero. It runs over the count byte and the packet bytes, takes each byte least significant bit first, and is sent low byte first. The same rule protects every response block the framer sends.
- R4: Each of the following gives no `cmd_valid`, and the next transmit flag returns the block with payload 0xFF:
  - a count byte outside 4..39, which ends the block at once;
  - a count byte of 4..6, which leaves a packet too short for the fixed fields;
  - a CRC mismatch.
- R5: From `cmd_valid` until `eng_done`, `busy` is 1 and every incoming byte is ignored, so a transmit flag in that window produces no output.
- R6: If `eng_done` arrives with `eng_ok`=1, the response block becomes count `eng_rsp_len`+3, followed by the payload bytes written through the engine write port at addresses 0..len-1, then the CRC. If `eng_ok`=0, the response block carries payload 0x0F.
- R7: Repeated transmit flags resend the same complete response block.
- R8: Flag 0xCC sets `asleep`. While asleep, every byte is ignored. A `wake` pulse clears `asleep` and restores the 0x11 status response.
- R9: Any flag value other than 0x77, 0x88 and 0xCC produces no output and leaves the current response unchanged.
- R10: While `tx_valid` is 1 and `tx_ready` is 0, `tx_valid` stays 1 and `tx_byte` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wake | input | 1 | Wake event from the token layer |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| tx_ready | input | 1 | Token layer accepts `tx_byte` |
| tx_valid | output | 1 | Response byte available |
| tx_byte | output | 8 | Response byte |
| asleep | output | 1 | Link asleep |
| busy | output | 1 | Command handed to engine, not yet done |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_opcode | output | 8 | Packet byte 0 |
| cmd_param1 | output | 8 | Packet byte 1 |
| cmd_param2 | output | 16 | Packet bytes 2..3, little-endian |
| cmd_data_len | output | 6 | Number of data bytes |
| eng_rd_addr | input | 5 | Data read address |
| eng_rd_data | output | 8 | Data read value, one cycle latency |
| eng_wr_en | input | 1 | Result buffer write enable |
| eng_wr_addr | input | 5 | Result buffer address |
| eng_wr_data | input | 8 | Result buffer byte |
| eng_done | input | 1 | Engine finished |
| eng_ok | input | 1 | Engine result valid (0 gives 0x0F) |
| eng_rsp_len | input | 6 | Result payload length, 1..32 |

## Verification
The assertions take three things for granted:
- the engine raises `eng_done` only while `busy` is high;
- it writes the result buffer only in that window, and `eng_rsp_len` lies in 1..32;
- the token layer sends no bytes while a response is still going out.

The stimulus respects these limits as follows. The bench engine model acts only after it has seen `cmd_valid`. Each flag is sent only after the previous response has been fully collected. Random traffic draws data lengths from 0..32 and result lengths from 1..32. `tx_ready` is randomly withheld on about a quarter of the cycles.

// File: rtl/cmd_framer_pkg.sv
package cmd_framer_pkg;
  localparam logic [7:0]  FLAG_CMD   = 8'h77;
  localparam logic [7:0]  FLAG_TX    = 8'h88;
  localparam logic [7:0]  FLAG_SLEEP = 8'hCC;
  localparam logic [7:0]  ST_WAKE    = 8'h11;
  localparam logic [7:0]  ST_EXEC    = 8'h0F;
  localparam logic [7:0]  ST_PARSE   = 8'hFF;
  localparam logic [15:0] CRC_POLY   = 16'h8005;

  // Bit-serial update, one data bit per step, LSB of the byte first.
  function automatic logic [15:0] crc16_byte(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (d[i] ^ r[15]) r = (r << 1) ^ CRC_POLY;
      else              r = r << 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/cmd_crc16.sv
module cmd_crc16
  import cmd_framer_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        clr,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [15:0] crc
);
  always_ff @(posedge clk) begin
    if (rst || clr) crc <= '0;
    else if (en)    crc <= crc16_byte(crc, din);
  end
endmodule

// File: rtl/cmd_rx.sv
module cmd_rx
  import cmd_framer_pkg::*;
#(
  parameter  int BLK_MAX  = 39,
  localparam int DATA_MAX = BLK_MAX - 7,
  localparam int DAW      = $clog2(DATA_MAX),
  localparam int DLW      = $clog2(DATA_MAX + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wake,
  input  logic           rx_valid,
  input  logic [7:0]     rx_byte,
  input  logic           tx_active,
  input  logic           eng_done,
  input  logic [DAW-1:0] eng_rd_addr,
  output logic [7:0]     eng_rd_data,
  output logic           cmd_valid,
  output logic [7:0]     cmd_opcode,
  output logic [7:0]     cmd_param1,
  output logic [15:0]    cmd_param2,
  output logic [DLW-1:0] cmd_data_len,
  output logic           busy,
  output logic           asleep,
  output logic           tx_req,
  output logic           st_set,
  output logic [7:0]     st_code
);
  typedef enum logic [1:0] {S_FLAG, S_BLOCK, S_BUSY} rx_st_t;

  localparam logic [7:0] CNT_MIN = 8'd4;
  localparam logic [7:0] CNT_MAX = 8'(BLK_MAX);
  localparam logic [7:0] CNT_CMD = 8'd7;   // smallest count holding all fixed fields

  rx_st_t      st;
  logic [7:0]  cnt, idx, crc_lo;
  logic [15:0] crc;
  logic        take, in_blk, crc_en, dat_we;
  logic [7:0]  dmem [DATA_MAX];

  assign take = rx_valid && !tx_active && !asleep;

  always_comb begin
    in_blk = take && (st == S_BLOCK);
    crc_en = in_blk && ((idx == 8'd0) || (idx < cnt - 8'd2));
    dat_we = in_blk && (idx >= 8'd5) && (idx < cnt - 8'd2);
  end

  cmd_crc16 u_crc (
    .clk (clk),
    .rst (rst),
    .clr (st != S_BLOCK),
    .en  (crc_en),
    .din (rx_byte),
    .crc (crc)
  );

  // Data area: simple dual-port, registered read.
  always_ff @(posedge clk) begin
    if (dat_we) dmem[DAW'(idx - 8'd5)] <= rx_byte;
    eng_rd_data <= dmem[eng_rd_addr];
  end

  always_ff @(posedge clk) begin
    cmd_valid <= 1'b0;
    tx_req    <= 1'b0;
    st_set    <= 1'b0;
    if (rst) begin
      st           <= S_FLAG;
      asleep       <= 1'b0;
      busy         <= 1'b0;
      cnt          <= '0;
      idx          <= '0;
      crc_lo       <= '0;
      st_code      <= ST_WAKE;
      cmd_opcode   <= '0;
      cmd_param1   <= '0;
      cmd_param2   <= '0;
      cmd_data_len <= '0;
    end else if (asleep) begin
      if (wake) begin
        asleep  <= 1'b0;
        st_set  <= 1'b1;
        st_code <= ST_WAKE;
      end
    end else begin
      case (st)
        S_FLAG: if (take) begin
          case (rx_byte)
            FLAG_CMD:   begin st <= S_BLOCK; idx <= '0; end
            FLAG_TX:    tx_req <= 1'b1;
            FLAG_SLEEP: asleep <= 1'b1;
            default:    ;
          endcase
        end
        S_BLOCK: if (take) begin
          idx <= idx + 8'd1;
          if (idx == 8'd0) begin
            cnt <= rx_byte;
            if (rx_byte < CNT_MIN || rx_byte > CNT_MAX) begin
              st_set  <= 1'b1;
              st_code <= ST_PARSE;
              st      <= S_FLAG;
            end
          end else if (idx == cnt - 8'd2) begin
            crc_lo <= rx_byte;
          end else if (idx == cnt - 8'd1) begin
            if ({rx_byte, crc_lo} == crc && cnt >= CNT_CMD) begin
              cmd_valid    <= 1'b1;
              busy         <= 1'b1;
              cmd_data_len <= DLW'(cnt - CNT_CMD);
              st           <= S_BUSY;
            end else begin
              st_set  <= 1'b1;
              st_code <= ST_PARSE;
              st      <= S_FLAG;
            end
          end else begin
            case (idx)
              8'd1:    cmd_opcode        <= rx_byte;
              8'd2:    cmd_param1        <= rx_byte;
              8'd3:    cmd_param2[7:0]   <= rx_byte;
              8'd4:    cmd_param2[15:8]  <= rx_byte;
              default: ;
            endcase
          end
        end
        S_BUSY: if (eng_done) begin
          busy <= 1'b0;
          st   <= S_FLAG;
        end
        default: st <= S_FLAG;
      endcase
    end
  end

  // R4
  cmd_count_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> (cnt >= CNT_CMD && cnt <= CNT_MAX));

  // R8
  sleep_idle_chk: assert property (@(posedge clk) disable iff (rst)
    asleep |-> (!busy && !cmd_valid));
endmodule

// File: rtl/cmd_tx.sv
module cmd_tx
  import cmd_framer_pkg::*;
#(
  parameter  int RSP_MAX = 32,
  localparam int RAW     = $clog2(RSP_MAX),
  localparam int RLW     = $clog2(RSP_MAX + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           st_set,
  input  logic [7:0]     st_code,
  input  logic           eng_done,
  input  logic           eng_ok,
  input  logic [RLW-1:0] eng_rsp_len,
  input  logic           eng_wr_en,
  input  logic [RAW-1:0] eng_wr_addr,
  input  logic [7:0]     eng_wr_data,
  input  logic           tx_req,
  input  logic           tx_ready,
  output logic           tx_valid,
  output logic [7:0]     tx_byte,
  output logic           tx_active
);
  localparam logic [7:0] CNT_TOP = 8'(RSP_MAX + 3);

  logic           use_mem;
  logic [7:0]     code;
  logic [RLW-1:0] plen;
  logic [7:0]     rmem [RSP_MAX];
  logic [7:0]     idx, plen8, total, cur;
  logic [15:0]    crc;
  logic           load, crc_en;

  assign plen8 = 8'(plen);
  assign total = plen8 + 8'd3;

  always_comb begin
    if (idx == 8'd0)               cur = total;
    else if (idx <= plen8)         cur = use_mem ? rmem[RAW'(idx - 8'd1)] : code;
    else if (idx == total - 8'd2)  cur = crc[7:0];
    else                           cur = crc[15:8];
    load   = tx_active && (idx != total) && (!tx_valid || tx_ready);
    crc_en = load && (idx < total - 8'd2);
  end

  cmd_crc16 u_crc (
    .clk (clk),
    .rst (rst),
    .clr (!tx_active),
    .en  (crc_en),
    .din (cur),
    .crc (crc)
  );

  always_ff @(posedge clk) begin
    if (eng_wr_en) rmem[eng_wr_addr] <= eng_wr_data;
  end

  // Current response selection
  always_ff @(posedge clk) begin
    if (rst) begin
      use_mem <= 1'b0;
      code    <= ST_WAKE;
      plen    <= RLW'(1);
    end else if (st_set) begin
      use_mem <= 1'b0;
      code    <= st_code;
      plen    <= RLW'(1);
    end else if (eng_done) begin
      use_mem <= eng_ok;
      code    <= ST_EXEC;
      plen    <= eng_ok ? eng_rsp_len : RLW'(1);
    end
  end

  // Byte sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_active <= 1'b0;
      tx_valid  <= 1'b0;
      tx_byte   <= '0;
      idx       <= '0;
    end else if (tx_req && !tx_active) begin
      tx_active <= 1'b1;
      idx       <= '0;
    end else if (load) begin
      tx_byte  <= cur;
      tx_valid <= 1'b1;
      idx      <= idx + 8'd1;
    end else if (tx_valid && tx_ready) begin
      tx_valid  <= 1'b0;
      tx_active <= 1'b0;
    end
  end

  // R10
  tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte)));

  // R6
  tx_count_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_valid) |-> (tx_byte >= 8'd4 && tx_byte <= CNT_TOP));
endmodule

// File: rtl/cmd_framer.sv
module cmd_framer
  import cmd_framer_pkg::*;
#(
  parameter  int BLK_MAX  = 39,
  parameter  int RSP_MAX  = 32,
  localparam int DATA_MAX = BLK_MAX - 7,
  localparam int DAW      = $clog2(DATA_MAX),
  localparam int DLW      = $clog2(DATA_MAX + 1),
  localparam int RAW      = $clog2(RSP_MAX),
  localparam int RLW      = $clog2(RSP_MAX + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wake,
  input  logic           rx_valid,
  input  logic [7:0]     rx_byte,
  input  logic           tx_ready,
  output logic           tx_valid,
  output logic [7:0]     tx_byte,
  output logic           asleep,
  output logic           busy,
  output logic           cmd_valid,
  output logic [7:0]     cmd_opcode,
  output logic [7:0]     cmd_param1,
  output logic [15:0]    cmd_param2,
  output logic [DLW-1:0] cmd_data_len,
  input  logic [DAW-1:0] eng_rd_addr,
  output logic [7:0]     eng_rd_data,
  input  logic           eng_wr_en,
  input  logic [RAW-1:0] eng_wr_addr,
  input  logic [7:0]     eng_wr_data,
  input  logic           eng_done,
  input  logic           eng_ok,
  input  logic [RLW-1:0] eng_rsp_len
);
  logic       tx_active, tx_req, st_set;
  logic [7:0] st_code;

  cmd_rx #(.BLK_MAX(BLK_MAX)) u_rx (
    .clk          (clk),
    .rst          (rst),
    .wake         (wake),
    .rx_valid     (rx_valid),
    .rx_byte      (rx_byte),
    .tx_active    (tx_active),
    .eng_done     (eng_done),
    .eng_rd_addr  (eng_rd_addr),
    .eng_rd_data  (eng_rd_data),
    .cmd_valid    (cmd_valid),
    .cmd_opcode   (cmd_opcode),
    .cmd_param1   (cmd_param1),
    .cmd_param2   (cmd_param2),
    .cmd_data_len (cmd_data_len),
    .busy         (busy),
    .asleep       (asleep),
    .tx_req       (tx_req),
    .st_set       (st_set),
    .st_code      (st_code)
  );

  cmd_tx #(.RSP_MAX(RSP_MAX)) u_tx (
    .clk         (clk),
    .rst         (rst),
    .st_set      (st_set),
    .st_code     (st_code),
    .eng_done    (eng_done),
    .eng_ok      (eng_ok),
    .eng_rsp_len (eng_rsp_len),
    .eng_wr_en   (eng_wr_en),
    .eng_wr_addr (eng_wr_addr),
    .eng_wr_data (eng_wr_data),
    .tx_req      (tx_req),
    .tx_ready    (tx_ready),
    .tx_valid    (tx_valid),
    .tx_byte     (tx_byte),
    .tx_active   (tx_active)
  );

  // R5
  busy_silent_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> !tx_valid);

  // R8
  asleep_silent_chk: assert property (@(posedge clk) disable iff (rst)
    asleep |-> !tx_valid);
endmodule

// File: tb/cmd_framer_tb.sv
module cmd_framer_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst, wake, rx_valid, tx_ready, tx_valid, asleep, busy, cmd_valid;
  logic [7:0]  rx_byte, tx_byte, cmd_opcode, cmd_param1, eng_rd_data, eng_wr_data;
  logic [15:0] cmd_param2;
  logic [5:0]  cmd_data_len, eng_rsp_len;
  logic [4:0]  eng_rd_addr, eng_wr_addr;
  logic        eng_wr_en, eng_done, eng_ok;

  cmd_framer u_dut (
    .clk(clk), .rst(rst), .wake(wake), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_byte(tx_byte), .asleep(asleep),
    .busy(busy), .cmd_valid(cmd_valid), .cmd_opcode(cmd_opcode),
    .cmd_param1(cmd_param1), .cmd_param2(cmd_param2), .cmd_data_len(cmd_data_len),
    .eng_rd_addr(eng_rd_addr), .eng_rd_data(eng_rd_data), .eng_wr_en(eng_wr_en),
    .eng_wr_addr(eng_wr_addr), .eng_wr_data(eng_wr_data), .eng_done(eng_done),
    .eng_ok(eng_ok), .eng_rsp_len(eng_rsp_len)
  );

  int n_chk = 0, n_fail = 0, n_cmd = 0;
  bit finished = 0;
  logic [7:0] txq[$], expq[$], pq[$], blkq[$], datq[$], rspq[$];
  bit cmd_seen;
  logic [7:0] c_op, c_p1;
  logic [15:0] c_p2;
  logic [5:0] c_len;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // Bench CRC: 0x8005, zero start, bytes taken LSB first
  function automatic logic [15:0] bcrc(input logic [7:0] q[$]);
    logic [15:0] c;
    logic inb, top;
    c = 16'h0000;
    foreach (q[k]) begin
      for (int j = 0; j < 8; j++) begin
        inb = q[k][j];
        top = c[15];
        c = {c[14:0], 1'b0};
        if (inb != top) c = c ^ 16'h8005;
      end
    end
    return c;
  endfunction

  task automatic mkblk();
    logic [15:0] c;
    blkq.delete();
    blkq.push_back(8'(pq.size() + 3));
    foreach (pq[i]) blkq.push_back(pq[i]);
    c = bcrc(blkq);
    blkq.push_back(c[7:0]);
    blkq.push_back(c[15:8]);
  endtask

  task automatic expect_code(input logic [7:0] code);
    pq.delete();
    pq.push_back(code);
    mkblk();
    expq = blkq;
  endtask

  // Output collector with random backpressure
  always @(negedge clk) begin
    tx_ready = ($urandom % 4) != 0;
    #1;
    if (tx_valid && tx_ready) txq.push_back(tx_byte);
  end

  always @(negedge clk) begin
    if (cmd_valid) begin
      n_cmd++;
      cmd_seen = 1;
      c_op = cmd_opcode; c_p1 = cmd_param1; c_p2 = cmd_param2; c_len = cmd_data_len;
    end
  end

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_byte  = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic fetch(input string tag);
    int w;
    txq.delete();
    send(8'h88);
    w = 0;
    while (txq.size() < expq.size() && w < 800) begin
      @(negedge clk);
      w++;
    end
    repeat (20) @(negedge clk);
    chk(txq.size() == expq.size(), {tag, " block length"}, txq.size(), expq.size());
    if (txq.size() == expq.size())
      foreach (expq[i]) chk(txq[i] == expq[i], {tag, " block byte"}, txq[i], expq[i]);
  endtask

  task automatic silent(input string tag, input logic [7:0] flag);
    txq.delete();
    send(flag);
    repeat (60) @(negedge clk);
    chk(txq.size() == 0, {tag, " no output"}, txq.size(), 0);
  endtask

  task automatic send_blk(input bit bad);
    send(8'h77);
    foreach (blkq[i]) send((bad && i == blkq.size() - 1) ? (blkq[i] ^ 8'h5A) : blkq[i]);
  endtask

  initial begin
    int n0, dl, rl, w;
    bit bad, ok;
    logic [7:0] op, p1;
    logic [15:0] p2;
    void'($urandom(32'd20240611));
    rst = 1; wake = 0; rx_valid = 0; rx_byte = 0;
    eng_rd_addr = 0; eng_wr_en = 0; eng_wr_addr = 0; eng_wr_data = 0;
    eng_done = 0; eng_ok = 0; eng_rsp_len = 0;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(!tx_valid && !busy && !asleep && !cmd_valid, "R1 reset outputs",
        {tx_valid, busy, asleep, cmd_valid}, 0);

    // R1 wake status, R3 CRC on it, R7 replay
    expect_code(8'h11);
    fetch("R1 wake status R3");
    fetch("R7 replay status");

    // R9 other flag values ignored
    silent("R9 flag 0x55", 8'h55);
    silent("R9 flag 0x00", 8'h00);
    silent("R9 flag 0xFF", 8'hFF);
    fetch("R9 response unchanged");

    // R4 count out of range
    n0 = n_cmd;
    send(8'h77); send(8'd3);
    expect_code(8'hFF);
    fetch("R4 count 3");
    send(8'h77); send(8'd40);
    fetch("R4 count 40");
    // R4 packet too short for fixed fields
    pq.delete(); pq.push_back(8'hA1); pq.push_back(8'hB2);
    mkblk();
    send_blk(0);
    expect_code(8'hFF);
    fetch("R4 count 5");
    chk(n_cmd == n0, "R4 no command issued", n_cmd, n0);

    // Random traffic: R2 R3 R5 R6 R7 R4
    for (int it = 0; it < 30; it++) begin
      dl = (it == 0) ? 32 : (it == 1) ? 0 : int'($urandom % 33);
      op = 8'($urandom); p1 = 8'($urandom); p2 = 16'($urandom);
      pq.delete(); datq.delete();
      pq.push_back(op); pq.push_back(p1); pq.push_back(p2[7:0]); pq.push_back(p2[15:8]);
      for (int i = 0; i < dl; i++) begin
        datq.push_back(8'($urandom));
        pq.push_back(datq[i]);
      end
      mkblk();
      bad = (it > 1) && (($urandom % 6) == 0);
      cmd_seen = 0;
      n0 = n_cmd;
      send_blk(bad);
      if (bad) begin
        repeat (5) @(negedge clk);
        chk(n_cmd == n0, "R4 bad CRC no command", n_cmd, n0);
        expect_code(8'hFF);
        fetch("R4 bad CRC");
        continue;
      end
      w = 0;
      while (!cmd_seen && w < 50) begin @(negedge clk); w++; end
      chk(cmd_seen, "R2 command strobe", cmd_seen, 1);
      chk(c_op == op, "R2 opcode", c_op, op);
      chk(c_p1 == p1, "R2 param1", c_p1, p1);
      chk(c_p2 == p2, "R2 param2", c_p2, p2);
      chk(c_len == 6'(dl), "R2 data length", c_len, dl);
      for (int i = 0; i < dl; i++) begin
        @(negedge clk); eng_rd_addr = 5'(i);
        @(negedge clk);
        chk(eng_rd_data == datq[i], "R2 data byte", eng_rd_data, datq[i]);
      end
      rl = 1 + int'($urandom % 32);
      rspq.delete();
      for (int i = 0; i < rl; i++) begin
        rspq.push_back(8'($urandom));
        @(negedge clk);
        eng_wr_en = 1; eng_wr_addr = 5'(i); eng_wr_data = rspq[i];
      end
      @(negedge clk); eng_wr_en = 0;
      silent("R5 transmit while busy", 8'h88);
      chk(busy, "R5 busy held", busy, 1);
      ok = ($urandom % 5) != 0;
      @(negedge clk);
      eng_done = 1; eng_ok = ok; eng_rsp_len = 6'(rl);
      @(negedge clk);
      eng_done = 0;
      chk(!busy, "R5 busy released", busy, 0);
      if (ok) begin
        pq = rspq;
        mkblk();
        expq = blkq;
      end else expect_code(8'h0F);
      fetch("R6 result block R3");
      fetch("R7 replay result");
    end

    // R8 sleep and wake
    send(8'hCC);
    repeat (2) @(negedge clk);
    chk(asleep, "R8 asleep set", asleep, 1);
    silent("R8 transmit while asleep", 8'h88);
    n0 = n_cmd;
    pq.delete(); pq.push_back(8'h01); pq.push_back(8'h02); pq.push_back(8'h03); pq.push_back(8'h04);
    mkblk();
    send_blk(0);
    repeat (5) @(negedge clk);
    chk(n_cmd == n0, "R8 command ignored asleep", n_cmd, n0);
    @(negedge clk); wake = 1;
    @(negedge clk); wake = 0;
    @(negedge clk);
    chk(!asleep, "R8 asleep cleared", asleep, 0);
    expect_code(8'h11);
    fetch("R8 wake status");

    report();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    report();
  end
endmodule